// File: doc/BRIEF.md
# Single-to-Half Precision Converter

This block narrows a 32-bit binary floating-point operand to a 16-bit value. The operand is split into sign, exponent and significand, the significand is rounded to the narrow width under one of five rounding modes, and the result is packed with the five exception flags. The result and flags are held in a register, so they appear one clock after the operand is presented.

Two output encodings are selectable per operation. The standard encoding keeps infinities and NaNs at the all-ones exponent. The extended-range encoding has no infinity or NaN: the all-ones exponent is an ordinary binade, which doubles the largest magnitude. In that encoding, inputs or results that cannot be represented saturate or collapse to zero and raise invalid, never overflow. Further controls select when tininess is judged, whether subnormal inputs are flushed to zero, and whether NaN results are replaced by a single canonical NaN.

Top module: `s2h_convert`

## Requirements
- R1: A finite, in-range input rounds to the nearest 10-bit fraction in mode 0. On an exact tie it rounds up only when the kept lowest fraction bit is 1. Any discarded nonzero bit raises inexact (flag `nx_o`).
- R2: `rmode_i` selects the rounding: 0 nearest with ties to even, 1 nearest with ties away from zero, 2 toward plus infinity, 3 toward minus infinity, 4 toward zero. Codes 5 to 7 behave as code 4.
- R3: In standard encoding (`alt_i`=0), a result whose exponent field would exceed 30 gives a signed infinity (exponent 31, fraction 0) and raises overflow and inexact. This includes a rounding carry out of exponent 30.
- R4: In extended encoding (`alt_i`=1), exponent field 31 is a normal binade. A result beyond it gives the signed largest magnitude (exponent 31, fraction all ones) and raises only invalid. Overflow is never raised in this encoding.
- R5: In extended encoding, any NaN input gives a zero with the NaN's sign, and an infinite input gives the signed largest magnitude. Both raise invalid.
- R6: In standard encoding, an infinite input gives the same-signed infinity with no flags. A NaN input keeps its sign and the upper 9 bits below the quiet bit, with the quiet bit (fraction bit 9) set. A signalling input (input fraction bit 22 clear) also raises invalid.
- R7: With `dnan_i`=1 in standard encoding, every NaN input gives 0x7E00. Invalid is still raised for a signalling input.
- R8: Results below the smallest normal are rounded as subnormals. Underflow is raised only when the result is tiny and inexact. With `tiny_after_i`=0, tiny means the unrounded exponent lies below the normal range. With `tiny_after_i`=1, a value in the binade just under the smallest normal is not tiny if rounding carries it up to the smallest normal.
- R9: A magnitude far below the smallest subnormal gives a signed zero under nearest, toward-zero and opposite-direction rounding, and the smallest subnormal under rounding away in its own direction. Both cases raise inexact and underflow.
- R10: With `ftz_i`=1, a subnormal input gives a zero of the same sign and raises only the input-denormal flag. With `ftz_i`=0 it is rounded as a tiny value. The 16-bit result itself is never flushed.
- R11: While `rst_n` is low the result and all flags read 0. Otherwise each result and its flags appear one clock after the operand.
- R12: A zero input of either sign gives a zero of the same sign with no flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the output register |
| op_i | input | 32 | Single-precision operand |
| rmode_i | input | 3 | Rounding mode code (R2) |
| tiny_after_i | input | 1 | 1: judge tininess after rounding; 0: before |
| ftz_i | input | 1 | Flush subnormal inputs to signed zero |
| dnan_i | input | 1 | Replace NaN results with the canonical NaN |
| alt_i | input | 1 | 1: extended-range encoding without Inf/NaN |
| res_o | output | 16 | Half-precision result |
| nv_o | output | 1 | Invalid operation flag |
| of_o | output | 1 | Overflow flag |
| uf_o | output | 1 | Underflow flag |
| nx_o | output | 1 | Inexact flag |
| id_o | output | 1 | Input-denormal flag |

## Verification
The result and all five flags come from a single register stage, so each is due at the first rising edge after the operand and controls are applied. No flag settles earlier or later than the result. The bench changes inputs on a falling edge and compares result and flags on the following falling edge, half a period after the capturing edge. Each vector therefore takes one clock. Vectors run back to back, and every comparison covers exactly the previous vector.

// File: rtl/s2h_pkg.sv
package s2h_pkg;

   typedef enum logic [2:0] {
      RM_NEAR_EVEN = 3'd0,
      RM_NEAR_AWAY = 3'd1,
      RM_UP        = 3'd2,
      RM_DOWN      = 3'd3,
      RM_ZERO      = 3'd4
   } rmode_e;

   typedef struct packed {
      logic nv;
      logic of;
      logic uf;
      logic nx;
      logic id;
   } flags_t;

endpackage

// File: rtl/s2h_unpack.sv
// Splits the wide operand into class bits, significand and rebiased exponent.
module s2h_unpack #(
   parameter int SE  = 8,
   parameter int SM  = 23,
   parameter int DE  = 5,
   parameter int DM  = 10,
   parameter int BEW = 10
) (
   input  logic                  ftz,
   input  logic [SE+SM:0]        op,
   output logic                  sign,
   output logic                  is_nan,
   output logic                  is_snan,
   output logic                  is_inf,
   output logic                  is_zero,
   output logic                  flushed,
   output logic [SM:0]           sig,
   output logic signed [BEW-1:0] be,
   output logic [DM-2:0]         pay
);
   localparam int SRC_BIAS = (1 << (SE - 1)) - 1;
   localparam int DST_BIAS = (1 << (DE - 1)) - 1;
   localparam logic signed [BEW-1:0] BIAS_GAP = BEW'(SRC_BIAS - DST_BIAS);

   logic [SE-1:0] ef, ef_adj;
   logic [SM-1:0] ff;
   logic          e_all, e_none, f_any;

   assign ef     = op[SE+SM-1:SM];
   assign ff     = op[SM-1:0];
   assign e_all  = &ef;
   assign e_none = ~|ef;
   assign f_any  = |ff;

   assign sign    = op[SE+SM];
   assign is_nan  = e_all & f_any;
   assign is_snan = is_nan & ~ff[SM-1];
   assign is_inf  = e_all & ~f_any;
   assign flushed = e_none & f_any & ftz;
   assign is_zero = (e_none & ~f_any) | flushed;
   assign sig     = {~e_none, ff};
   assign ef_adj  = e_none ? SE'(1) : ef;
   assign be      = $signed({{(BEW-SE){1'b0}}, ef_adj}) - BIAS_GAP;
   assign pay     = ff[SM-2:SM-DM];

endmodule

// File: rtl/s2h_round.sv
// One shared right shifter serves normal and subnormal results alike.
module s2h_round
   import s2h_pkg::*;
#(
   parameter int SM  = 23,
   parameter int DM  = 10,
   parameter int BEW = 10
) (
   input  logic                  sign,
   input  logic [SM:0]           sig,
   input  logic signed [BEW-1:0] be,
   input  rmode_e                rm,
   output logic [DM-1:0]         frac,
   output logic signed [BEW-1:0] expf,
   output logic                  inexact,
   output logic                  tiny_pre,
   output logic                  tiny_post
);
   localparam int DROP = SM - DM;
   localparam int WW   = 2 * (SM + 1);
   localparam int SHW  = $clog2(WW);
   localparam logic signed [BEW-1:0] ONE    = BEW'(1);
   localparam logic signed [BEW-1:0] SH_CAP = BEW'(SM + 1);

   logic                  sub, rb, st, inc;
   logic signed [BEW-1:0] sh_s;
   logic [SHW-1:0]        sh;
   logic [WW-1:0]         wide;
   logic [SM:0]           up, low;
   logic [DM:0]           kept;
   logic [DM+1:0]         sum;

   always_comb begin
      sub  = (be < ONE);
      sh_s = ONE - be;
      if (!sub)                sh = '0;
      else if (sh_s > SH_CAP)  sh = SHW'(SM + 1);
      else                     sh = sh_s[SHW-1:0];
      wide = {sig, {(SM+1){1'b0}}} >> sh;
      up   = wide[WW-1:SM+1];
      low  = wide[SM:0];
      kept = up[SM:DROP];
      rb   = up[DROP-1];
      st   = (|up[DROP-2:0]) | (|low);
      case (rm)
         RM_NEAR_EVEN: inc = rb & (st | kept[0]);
         RM_NEAR_AWAY: inc = rb;
         RM_UP:        inc = ~sign & (rb | st);
         RM_DOWN:      inc = sign & (rb | st);
         default:      inc = 1'b0;
      endcase
      sum  = {1'b0, kept} + {{(DM+1){1'b0}}, inc};
      frac = sum[DM-1:0];
      if (sub) expf = sum[DM] ? ONE : '0;
      else     expf = be + $signed({{(BEW-1){1'b0}}, sum[DM+1]});
      inexact   = rb | st;
      tiny_pre  = sub;
      tiny_post = sub & ((be != '0) | ~sum[DM]);
   end

endmodule

// File: rtl/s2h_pack.sv
// Chooses between special encodings, saturation and the rounded value.
module s2h_pack
   import s2h_pkg::*;
#(
   parameter int DE  = 5,
   parameter int DM  = 10,
   parameter int BEW = 10
) (
   input  logic                  sign,
   input  logic                  is_nan,
   input  logic                  is_snan,
   input  logic                  is_inf,
   input  logic                  is_zero,
   input  logic                  flushed,
   input  logic [DM-2:0]         pay,
   input  logic [DM-1:0]         frac,
   input  logic signed [BEW-1:0] expf,
   input  logic                  inexact,
   input  logic                  tiny_pre,
   input  logic                  tiny_post,
   input  logic                  alt,
   input  logic                  dnan,
   input  logic                  tiny_sel,
   output logic [DE+DM:0]        res,
   output flags_t                flg
);
   localparam logic signed [BEW-1:0] LIM_STD = BEW'((1 << DE) - 2);
   localparam logic signed [BEW-1:0] LIM_ALT = BEW'((1 << DE) - 1);
   localparam logic [DE-1:0] E_TOP = '1;
   localparam logic [DM-1:0] F_ALL = '1;

   logic ovf;

   always_comb begin
      res = '0;
      flg = '0;
      ovf = expf > (alt ? LIM_ALT : LIM_STD);
      if (is_nan) begin
         flg.nv = alt | is_snan;
         if (alt)       res = {sign, {(DE+DM){1'b0}}};
         else if (dnan) res = {1'b0, E_TOP, 1'b1, {(DM-1){1'b0}}};
         else           res = {sign, E_TOP, 1'b1, pay};
      end else if (is_inf) begin
         flg.nv = alt;
         res    = alt ? {sign, E_TOP, F_ALL} : {sign, E_TOP, {DM{1'b0}}};
      end else if (is_zero) begin
         res    = {sign, {(DE+DM){1'b0}}};
         flg.id = flushed;
      end else if (ovf) begin
         if (alt) begin
            res    = {sign, E_TOP, F_ALL};
            flg.nv = 1'b1;
         end else begin
            res    = {sign, E_TOP, {DM{1'b0}}};
            flg.of = 1'b1;
            flg.nx = 1'b1;
         end
      end else begin
         res    = {sign, expf[DE-1:0], frac};
         flg.nx = inexact;
         flg.uf = inexact & (tiny_sel ? tiny_post : tiny_pre);
      end
   end

endmodule

// File: rtl/s2h_convert.sv
module s2h_convert
   import s2h_pkg::*;
#(
   parameter int SRC_EXP = 8,
   parameter int SRC_MAN = 23,
   parameter int DST_EXP = 5,
   parameter int DST_MAN = 10,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [SRC_EXP+SRC_MAN:0]   op_i,
   input  logic [2:0]                 rmode_i,
   input  logic                       tiny_after_i,
   input  logic                       ftz_i,
   input  logic                       dnan_i,
   input  logic                       alt_i,
   output logic [DST_EXP+DST_MAN:0]   res_o,
   output logic                       nv_o,
   output logic                       of_o,
   output logic                       uf_o,
   output logic                       nx_o,
   output logic                       id_o
);
   localparam int SW  = SRC_EXP + SRC_MAN + 1;
   localparam int DW  = DST_EXP + DST_MAN + 1;
   localparam int BEW = SRC_EXP + 2;
   localparam int SRC_BIAS = (1 << (SRC_EXP - 1)) - 1;
   localparam int DST_BIAS = (1 << (DST_EXP - 1)) - 1;

   if (DST_EXP >= SRC_EXP) begin : g_bad_exp
      $error("s2h_convert: destination exponent must be narrower");
   end
   if (SRC_MAN - DST_MAN < 2 || DST_MAN < 2) begin : g_bad_man
      $error("s2h_convert: fraction widths leave no guard and sticky bits");
   end
   if (SRC_BIAS <= DST_BIAS + DST_MAN) begin : g_bad_range
      $error("s2h_convert: source subnormals must lie below destination range");
   end

   logic                  u_sign, u_nan, u_snan, u_inf, u_zero, u_flush;
   logic [SRC_MAN:0]      u_sig;
   logic signed [BEW-1:0] u_be, r_expf;
   logic [DST_MAN-2:0]    u_pay;
   logic [DST_MAN-1:0]    r_frac;
   logic                  r_nx, r_tpre, r_tpost;
   logic [DW-1:0]         c_res;
   flags_t                c_flg;

   s2h_unpack #(.SE(SRC_EXP), .SM(SRC_MAN), .DE(DST_EXP), .DM(DST_MAN), .BEW(BEW)) u_unpack (
      .ftz(ftz_i), .op(op_i), .sign(u_sign), .is_nan(u_nan), .is_snan(u_snan),
      .is_inf(u_inf), .is_zero(u_zero), .flushed(u_flush), .sig(u_sig), .be(u_be), .pay(u_pay)
   );

   s2h_round #(.SM(SRC_MAN), .DM(DST_MAN), .BEW(BEW)) u_round (
      .sign(u_sign), .sig(u_sig), .be(u_be), .rm(rmode_e'(rmode_i)), .frac(r_frac),
      .expf(r_expf), .inexact(r_nx), .tiny_pre(r_tpre), .tiny_post(r_tpost)
   );

   s2h_pack #(.DE(DST_EXP), .DM(DST_MAN), .BEW(BEW)) u_pack (
      .sign(u_sign), .is_nan(u_nan), .is_snan(u_snan), .is_inf(u_inf), .is_zero(u_zero),
      .flushed(u_flush), .pay(u_pay), .frac(r_frac), .expf(r_expf), .inexact(r_nx),
      .tiny_pre(r_tpre), .tiny_post(r_tpost), .alt(alt_i), .dnan(dnan_i),
      .tiny_sel(tiny_after_i), .res(c_res), .flg(c_flg)
   );

   if (OUT_REG) begin : g_reg
      logic primed;
      localparam logic [DW-1:0] DNAN_W = {1'b0, {DST_EXP{1'b1}}, 1'b1, {(DST_MAN-1){1'b0}}};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_o  <= '0;
            {nv_o, of_o, uf_o, nx_o, id_o} <= '0;
            primed <= 1'b0;
         end else begin
            res_o  <= c_res;
            {nv_o, of_o, uf_o, nx_o, id_o} <= c_flg;
            primed <= 1'b1;
         end
      end

      AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rst_n)
         of_o |-> nx_o && !nv_o && res_o[DW-2:0] == {{DST_EXP{1'b1}}, {DST_MAN{1'b0}}});   // R3
      AST_ALT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(alt_i) |-> !of_o);   // R4
      AST_ALT_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(alt_i && (&op_i[SW-2:SRC_MAN]) && (|op_i[SRC_MAN-1:0]))
         |-> nv_o && res_o[DW-2:0] == '0);   // R5
      AST_DEFAULT_NAN: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(dnan_i && !alt_i && (&op_i[SW-2:SRC_MAN]) && (|op_i[SRC_MAN-1:0]))
         |-> res_o == DNAN_W);   // R7
      AST_UF_NEEDS_NX: assert property (@(posedge clk) disable iff (!rst_n)
         uf_o |-> nx_o);   // R8
      AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         primed && id_o |-> res_o[DW-2:0] == '0 && res_o[DW-1] == $past(op_i[SW-1]) && !nx_o);   // R10
   end else begin : g_comb
      assign res_o = c_res;
      assign {nv_o, of_o, uf_o, nx_o, id_o} = c_flg;
   end

endmodule

// File: tb/tb_s2h_convert.sv
module tb_s2h_convert;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic [31:0] op;
   logic [2:0]  rm;
   logic        ta, fz, dn, al;
   logic [15:0] res;
   logic        nv, of, uf, nx, id;
   int          n_run = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   s2h_convert dut (
      .clk(clk), .rst_n(rst_n), .op_i(op), .rmode_i(rm), .tiny_after_i(ta),
      .ftz_i(fz), .dnan_i(dn), .alt_i(al), .res_o(res), .nv_o(nv), .of_o(of),
      .uf_o(uf), .nx_o(nx), .id_o(id)
   );

   // Expected {result, nv, of, uf, nx, id} computed arithmetically.
   function automatic logic [20:0] ref_cvt(input logic [31:0] a, input int r, input bit alt,
                                           input bit t, input bit z, input bit d);
      logic   s;
      int     e, E, E2, q, sa, ef;
      longint f, M, N, rem, half;
      bit     inx, gt, eq, up, tap, ufl;
      s = a[31];
      e = int'(a[30:23]);
      f = longint'(a[22:0]);
      if (e == 255) begin
         if (f != 0) begin
            if (alt) return {s, 15'h0, 5'b10000};
            if (d)   return {16'h7E00, !a[22], 4'b0};
            return {s, 5'h1F, 1'b1, a[21:13], !a[22], 4'b0};
         end
         if (alt) return {s, 15'h7FFF, 5'b10000};
         return {s, 15'h7C00, 5'b0};
      end
      if (e == 0 && f == 0) return {s, 15'h0, 5'b0};
      if (e == 0 && z)      return {s, 15'h0, 5'b00001};
      M  = (e != 0) ? (f | (64'sd1 << 23)) : f;
      E  = (e != 0) ? e - 150 : -149;
      E2 = (e != 0) ? e - 127 : -127;
      q  = ((E2 < -14) ? -14 : E2) - 10;
      sa = q - E;
      if (sa > 40) sa = 40;
      N    = M >>> sa;
      rem  = M & ((64'sd1 << sa) - 1);
      half = 64'sd1 << (sa - 1);
      inx  = (rem != 0);
      gt   = (rem > half);
      eq   = (rem == half);
      case (r)
         0:       up = gt || (eq && N[0]);
         1:       up = gt || eq;
         2:       up = !s && inx;
         3:       up = s && inx;
         default: up = 1'b0;
      endcase
      N = N + longint'(up);
      if (E2 < -14) begin
         tap = (E2 < -15) || (N < 1024);
         ufl = inx && (t ? tap : 1'b1);
         return {s, (N >= 1024) ? 5'd1 : 5'd0, N[9:0], 2'b00, ufl, inx, 1'b0};
      end
      ef = E2 + 15;
      if (N == 2048) begin
         ef = ef + 1;
         N  = 1024;
      end
      if (ef > (alt ? 31 : 30)) begin
         if (alt) return {s, 15'h7FFF, 5'b10000};
         return {s, 15'h7C00, 5'b01010};
      end
      N = N - 1024;
      return {s, 5'(ef), N[9:0], 3'b000, inx, 1'b0};
   endfunction

   function automatic string tag_for(input logic [31:0] a, input bit alt, input bit z,
                                     input bit d, input logic [20:0] ex);
      if (&a[30:23]) return alt ? "R5" : ((d && |a[22:0]) ? "R7" : "R6");
      if (a[30:23] == 0 && a[22:0] != 0 && z) return "R10";
      if (a[30:0] == 0) return "R12";
      if (ex[3]) return "R3";
      if (alt && ex[4]) return "R4";
      if (ex[2]) return "R8";
      if (ex[19:5] == 0) return "R9";
      return "R2";
   endfunction

   function automatic logic [20:0] got();
      return {res, nv, of, uf, nx, id};
   endfunction

   task automatic chk(input string tag, input logic [31:0] a, input logic [20:0] exp_v);
      logic [20:0] g;
      g = got();
      n_run++;
      if (g !== exp_v) begin
         n_fail++;
         $display("FAIL %s op=%h rm=%0d alt=%0b got res=%h flags=%b exp res=%h flags=%b",
                  tag, a, rm, al, g[20:5], g[4:0], exp_v[20:5], exp_v[4:0]);
      end
   endtask

   // Drive at a falling edge; result is captured at the next rising edge
   // and compared at the falling edge after it.
   task automatic go(input logic [31:0] a, input int r, input bit alt, input bit t,
                     input bit z, input bit d);
      op = a; rm = 3'(r); al = alt; ta = t; fz = z; dn = d;
      @(negedge clk);
   endtask

   task automatic run_ref(input logic [31:0] a, input int r, input bit alt, input bit t,
                          input bit z, input bit d);
      logic [20:0] ex;
      ex = ref_cvt(a, r, alt, t, z, d);
      go(a, r, alt, t, z, d);
      chk(tag_for(a, alt, z, d, ex), a, ex);
   endtask

   initial begin
      logic [31:0] lf;
      rst_n = 1'b0;
      op = 32'h3F80_0000; rm = '0; ta = 1'b0; fz = 1'b0; dn = 1'b0; al = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11", op, 21'h0);   // R11 reset state
      rst_n = 1'b1;
      @(negedge clk);

      go(32'h3F80_0000, 0, 0, 0, 0, 0); chk("R1", op, {16'h3C00, 5'b00000});
      go(32'h3F80_1000, 0, 0, 0, 0, 0); chk("R1", op, {16'h3C00, 5'b00010});
      go(32'h3F80_3000, 0, 0, 0, 0, 0); chk("R1", op, {16'h3C02, 5'b00010});
      go(32'h3F80_1000, 1, 0, 0, 0, 0); chk("R2", op, {16'h3C01, 5'b00010});
      go(32'h3F80_0001, 2, 0, 0, 0, 0); chk("R2", op, {16'h3C01, 5'b00010});
      go(32'hBF80_0001, 3, 0, 0, 0, 0); chk("R2", op, {16'hBC01, 5'b00010});
      go(32'hBF80_1FFF, 4, 0, 0, 0, 0); chk("R2", op, {16'hBC00, 5'b00010});
      go(32'hBF80_1FFF, 6, 0, 0, 0, 0); chk("R2", op, {16'hBC00, 5'b00010});
      go(32'h477F_E000, 0, 0, 0, 0, 0); chk("R3", op, {16'h7BFF, 5'b00000});
      go(32'h477F_F000, 0, 0, 0, 0, 0); chk("R3", op, {16'h7C00, 5'b01010});
      go(32'h477F_F000, 4, 0, 0, 0, 0); chk("R3", op, {16'h7BFF, 5'b00010});
      go(32'h477F_F000, 0, 1, 0, 0, 0); chk("R4", op, {16'h7C00, 5'b00010});
      go(32'h47FF_E000, 0, 1, 0, 0, 0); chk("R4", op, {16'h7FFF, 5'b00000});
      go(32'hC800_0000, 0, 1, 0, 0, 0); chk("R4", op, {16'hFFFF, 5'b10000});
      go(32'hFFC0_0000, 0, 1, 0, 0, 0); chk("R5", op, {16'h8000, 5'b10000});
      go(32'hFF80_0000, 0, 1, 0, 0, 0); chk("R5", op, {16'hFFFF, 5'b10000});
      go(32'h7F80_2000, 0, 0, 0, 0, 0); chk("R6", op, {16'h7E01, 5'b10000});
      go(32'hFFC0_0000, 0, 0, 0, 0, 0); chk("R6", op, {16'hFE00, 5'b00000});
      go(32'hFF80_0000, 0, 0, 0, 0, 0); chk("R6", op, {16'hFC00, 5'b00000});
      go(32'hFFC0_0000, 0, 0, 0, 0, 1); chk("R7", op, {16'h7E00, 5'b00000});
      go(32'hFF80_0001, 0, 0, 0, 0, 1); chk("R7", op, {16'h7E00, 5'b10000});
      go(32'h3380_0000, 0, 0, 0, 0, 0); chk("R8", op, {16'h0001, 5'b00000});
      go(32'h33C0_0000, 0, 0, 0, 0, 0); chk("R8", op, {16'h0002, 5'b00110});
      go(32'h387F_F000, 0, 0, 0, 0, 0); chk("R8", op, {16'h0400, 5'b00110});
      go(32'h387F_F000, 0, 0, 1, 0, 0); chk("R8", op, {16'h0400, 5'b00010});
      go(32'h2E00_0000, 0, 0, 0, 0, 0); chk("R9", op, {16'h0000, 5'b00110});
      go(32'h2E00_0000, 2, 0, 0, 0, 0); chk("R9", op, {16'h0001, 5'b00110});
      go(32'hAE00_0000, 4, 0, 0, 0, 0); chk("R9", op, {16'h8000, 5'b00110});
      go(32'h0000_0001, 0, 0, 0, 1, 0); chk("R10", op, {16'h0000, 5'b00001});
      go(32'h8040_0000, 0, 1, 0, 1, 0); chk("R10", op, {16'h8000, 5'b00001});
      go(32'h0000_0001, 0, 0, 0, 0, 0); chk("R10", op, {16'h0000, 5'b00110});
      go(32'h8000_0000, 0, 0, 0, 0, 0); chk("R12", op, {16'h8000, 5'b00000});
      go(32'h0000_0000, 2, 1, 0, 1, 1); chk("R12", op, {16'h0000, 5'b00000});

      lf = 32'hACE1_2468;
      for (int a2 = 0; a2 < 2; a2++) begin
         for (int r = 0; r < 5; r++) begin
            for (int e = 0; e < 256; e++) begin
               for (int k = 0; k < 8; k++) begin
                  logic [22:0] fr;
                  logic [31:0] v;
                  lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                  case (k)
                     0: fr = 23'h0;
                     1: fr = 23'h1;
                     2: fr = 23'h001000;
                     3: fr = 23'h000FFF;
                     4: fr = 23'h001FFF;
                     5: fr = 23'h7FE000;
                     6: fr = 23'h7FF000;
                     default: fr = lf[22:0];
                  endcase
                  v = {1'(k) ^ 1'(e >> 2), 8'(e), fr};
                  run_ref(v, r, a2[0], e[0], k[1], e[1]);
               end
            end
         end
      end

      for (int i = 0; i < 4000; i++) begin
         logic [31:0] v;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         v = lf;
         v[30:23] = 8'(8'd95 + 8'(lf[7:2] % 6'd63));
         run_ref(v, i % 8, lf[10], lf[11], lf[12], lf[13]);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete (R11)");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule